// File: doc/BRIEF.md
# Request Response Transaction Manager

This block keeps one command at a time on a serial link to a companion controller. Several local requesters offer commands, each made of an identifier, a length and up to `PAY_BYTES` payload bytes. A fixed-priority arbiter takes one request per cycle. If the link is idle, the request goes straight into the in-flight slot. Otherwise it waits in a small first-in first-out pending queue. The slot presents its command to the frame transmitter through a valid/ready pair.

On the receive side, the block parses the incoming byte stream into frames and checks each frame's checksum. It then classifies every good frame by its 4-bit identifier:
- A synchronous reply whose identifier equals the in-flight command completes that command. The owning requester gets a one-cycle completion pulse with the reply length and bytes, and the next queued command is launched.
- A synchronous reply that matches nothing is reported as out-of-band.
- Keyboard and touch frames are forwarded as events.
- Any other identifier raises an unknown-message pulse.

A link-reset input aborts the in-flight command and sends the receiver back to hunting for a start byte.

Top module: `txn_mgr`

## Requirements
- R1: After reset `cmd_valid`, `done`, `key_evt`, `touch_evt`, `oob_evt` and `unknown_evt` are low, and every requester sees `req_ready` high while no request is offered.
- R2: A frame is the start byte 0x02, then a header byte (identifier in bits 7:4, length in bits 3:0), then that many data bytes, then a checksum equal to the 8-bit sum of the header and data bytes. Bytes other than 0x02 are skipped while hunting. A frame with a wrong checksum is dropped without any output.
- R3: At most one command is outstanding. While it is, `cmd_valid` and `cmd_id` hold that command until it is accepted, and no other command is presented until it completes.
- R4: A good frame with a synchronous identifier equal to the accepted in-flight identifier pulses `done[owner]` for one cycle, with `rsp_ok`=1, `out_len`=the frame length, and data byte k on `out_data[8k+7:8k]`. This happens two clock edges after the checksum byte is sampled.
- R5: Queued commands are launched in arrival order, each one as the previous completes.
- R6: The queue holds `QDEPTH` (4) commands besides the in-flight one. While it is full, `req_ready` is low.
- R7: A synchronous frame (identifiers 0, 1, 2, 6, 8, 9, 13) with no command in flight, or with a different identifier, pulses `oob_evt` and completes nothing.
- R8: Identifier 4 pulses `key_evt` and identifier 5 pulses `touch_evt`, each with the frame on `out_len`/`out_data`. The in-flight command is left untouched.
- R9: Identifiers 3, 7, 10, 11, 12, 14 and 15 pulse `unknown_evt`.
- R10: `link_rst` with a command in flight pulses `done[owner]` with `rsp_ok`=0 and `out_len`=0 on the next edge. It also discards any partly received frame, so the receiver hunts for a new start byte.
- R11: When several requesters offer in the same cycle, only the lowest-indexed one sees `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_rst | input | 1 | Abort in-flight command and re-hunt receiver |
| req_valid | input | NREQ | Request offered, one bit per requester |
| req_ready | output | NREQ | Request taken this cycle |
| req_id | input | NREQ*4 | Command identifier per requester |
| req_len | input | NREQ*4 | Command payload length per requester |
| req_data | input | NREQ*PAY_BYTES*8 | Command payload per requester |
| cmd_valid | output | 1 | Command for the frame transmitter |
| cmd_ready | input | 1 | Transmitter accepts the command |
| cmd_id | output | 4 | Command identifier |
| cmd_len | output | 4 | Command payload length |
| cmd_data | output | PAY_BYTES*8 | Command payload |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| done | output | NREQ | Completion pulse per requester |
| rsp_ok | output | 1 | Completion carried a real reply |
| out_len | output | 4 | Length of reply or event frame |
| out_data | output | 120 | Bytes of reply or event frame |
| key_evt | output | 1 | Keyboard event pulse |
| touch_evt | output | 1 | Touch event pulse |
| oob_evt | output | 1 | Unmatched synchronous reply pulse |
| unknown_evt | output | 1 | Unknown identifier pulse |

## Verification
A wrong slot state shows up within one frame time:
- A busy flag stuck low turns every reply into `oob_evt` with no `done`.
- A busy flag stuck high freezes `cmd_valid` and starves the queue.

Queue pointer faults show as launch-order errors on `cmd_id` at the next completion. A miscounted fill level shows as `req_ready` on the fifth or sixth request. Parser faults appear at the next frame: a missing or extra pulse, or a wrong `out_len` or byte, two edges after the checksum.

// File: rtl/txn_pkg.sv
// Shared constants and identifier classification for the transaction manager.
// Assumes a 4-bit identifier and a 4-bit length field in the frame header.
package txn_pkg;
    localparam int ID_W      = 4;
    localparam int LEN_W     = 4;
    localparam int MAX_BYTES = (1 << LEN_W) - 1;
    localparam logic [7:0] SOF_BYTE = 8'h02;

    typedef enum logic [1:0] {
        CLS_SYNC    = 2'd0,
        CLS_KEY     = 2'd1,
        CLS_TOUCH   = 2'd2,
        CLS_UNKNOWN = 2'd3
    } id_class_e;

    // Map an identifier to its traffic class.
    function automatic id_class_e classify(input logic [ID_W-1:0] id);
        case (id)
            4'd0, 4'd1, 4'd2, 4'd6, 4'd8, 4'd9, 4'd13: classify = CLS_SYNC;
            4'd4:    classify = CLS_KEY;
            4'd5:    classify = CLS_TOUCH;
            default: classify = CLS_UNKNOWN;
        endcase
    endfunction
endpackage

// File: rtl/txn_req_arb.sv
// Fixed-priority request arbiter: the lowest-indexed valid requester wins.
// Assumes ready may depend on valid, and enable says whether anything can be taken.
module txn_req_arb #(
    parameter int NREQ = 2,
    localparam int OWN_W = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic [NREQ-1:0]  valid,
    input  logic             enable,
    output logic [NREQ-1:0]  ready,
    output logic             fire,
    output logic [OWN_W-1:0] winner
);
    logic seen;

    // Walk requesters from index 0 upward and grant the first valid one.
    always_comb begin
        ready  = '0;
        fire   = 1'b0;
        winner = '0;
        seen   = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            ready[i] = enable && !seen;
            if (valid[i] && !seen) begin
                winner = OWN_W'(i);
                fire   = enable;
            end
            seen = seen | valid[i];
        end
    end
endmodule

// File: rtl/txn_pend_fifo.sv
// Pending-command queue, first in first out, with registered storage.
// Assumes the caller never pushes when full nor pops when empty.
module txn_pend_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;

    assign rdata = mem[rd_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));

    // Store the pushed entry at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= wdata;
    end

    // Advance pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/txn_frame_rx.sv
// Byte-stream frame parser: start byte, header, data bytes, additive checksum.
// Emits a one-cycle pulse per good frame; the fields hold until the next header.
module txn_frame_rx
    import txn_pkg::*;
#(
    parameter logic [7:0] SOF = SOF_BYTE
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   in_valid,
    input  logic [7:0]             in_byte,
    output logic                   fr_valid,
    output logic [ID_W-1:0]        fr_id,
    output logic [LEN_W-1:0]       fr_len,
    output logic [MAX_BYTES*8-1:0] fr_data
);
    typedef enum logic [1:0] {RX_HUNT, RX_HEAD, RX_BODY, RX_SUM} rx_state_e;

    rx_state_e      st_q;
    logic [LEN_W-1:0] cnt_q;
    logic [7:0]     sum_q;
    logic [7:0]     bytes_q [MAX_BYTES];

    // Present the stored bytes as one flat bus.
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_flat
        assign fr_data[g*8 +: 8] = bytes_q[g];
    end

    // Frame state machine with running checksum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= RX_HUNT;
            cnt_q    <= '0;
            sum_q    <= '0;
            fr_valid <= 1'b0;
            fr_id    <= '0;
            fr_len   <= '0;
            for (int i = 0; i < MAX_BYTES; i++) bytes_q[i] <= '0;
        end else begin
            fr_valid <= 1'b0;
            if (flush) begin
                st_q <= RX_HUNT;
            end else if (in_valid) begin
                case (st_q)
                    RX_HUNT: if (in_byte == SOF) st_q <= RX_HEAD;
                    RX_HEAD: begin
                        fr_id  <= in_byte[7:4];
                        fr_len <= in_byte[3:0];
                        sum_q  <= in_byte;
                        cnt_q  <= '0;
                        for (int i = 0; i < MAX_BYTES; i++) bytes_q[i] <= '0;
                        st_q   <= (in_byte[3:0] != '0) ? RX_BODY : RX_SUM;
                    end
                    RX_BODY: begin
                        bytes_q[cnt_q] <= in_byte;
                        sum_q <= sum_q + in_byte;
                        cnt_q <= cnt_q + 1'b1;
                        if (LEN_W'(cnt_q + 1'b1) == fr_len) st_q <= RX_SUM;
                    end
                    default: begin
                        fr_valid <= (in_byte == sum_q);
                        st_q     <= RX_HUNT;
                    end
                endcase
            end
        end
    end

    p_body_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_BODY) |-> (cnt_q < fr_len));
    p_flush_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !fr_valid);
endmodule

// File: rtl/txn_mgr.sv
// Request/response transaction manager: one command in flight, a FIFO of pending
// commands, and classification of received frames into replies and events.
// Assumes the transmitter frames cmd_* itself and that replies follow acceptance.
module txn_mgr
    import txn_pkg::*;
#(
    parameter int NREQ      = 2,
    parameter int PAY_BYTES = 2,
    parameter int QDEPTH    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         link_rst,
    input  logic [NREQ-1:0]              req_valid,
    output logic [NREQ-1:0]              req_ready,
    input  logic [NREQ*ID_W-1:0]         req_id,
    input  logic [NREQ*LEN_W-1:0]        req_len,
    input  logic [NREQ*PAY_BYTES*8-1:0]  req_data,
    output logic                         cmd_valid,
    input  logic                         cmd_ready,
    output logic [ID_W-1:0]              cmd_id,
    output logic [LEN_W-1:0]             cmd_len,
    output logic [PAY_BYTES*8-1:0]       cmd_data,
    input  logic                         rx_valid,
    input  logic [7:0]                   rx_byte,
    output logic [NREQ-1:0]              done,
    output logic                         rsp_ok,
    output logic [LEN_W-1:0]             out_len,
    output logic [MAX_BYTES*8-1:0]       out_data,
    output logic                         key_evt,
    output logic                         touch_evt,
    output logic                         oob_evt,
    output logic                         unknown_evt
);
    localparam int OWN_W = (NREQ > 1) ? $clog2(NREQ) : 1;
    localparam int PAY_W = PAY_BYTES * 8;

    typedef struct packed {
        logic [OWN_W-1:0] owner;
        logic [ID_W-1:0]  id;
        logic [LEN_W-1:0] len;
        logic [PAY_W-1:0] data;
    } cmd_t;

    logic             can_accept, arb_fire;
    logic [OWN_W-1:0] arb_winner;
    logic             q_empty, q_full, q_push, q_pop;
    cmd_t             new_cmd, q_head, slot_q;
    logic             busy_q, sent_q;
    logic             direct_load, release_slot;
    logic             fr_valid, frame_ok, match, abort;
    logic [ID_W-1:0]  fr_id;
    logic [LEN_W-1:0] fr_len;
    logic [MAX_BYTES*8-1:0] fr_data;
    id_class_e        fr_cls;

    // A request can be taken when it goes straight to the idle slot or the queue has room.
    assign can_accept = (!busy_q && q_empty) || !q_full;

    txn_req_arb #(.NREQ(NREQ)) u_arb (
        .valid  (req_valid),
        .enable (can_accept),
        .ready  (req_ready),
        .fire   (arb_fire),
        .winner (arb_winner)
    );

    // Gather the winning requester's command fields.
    always_comb begin
        new_cmd.owner = arb_winner;
        new_cmd.id    = req_id[int'(arb_winner)*ID_W +: ID_W];
        new_cmd.len   = req_len[int'(arb_winner)*LEN_W +: LEN_W];
        new_cmd.data  = req_data[int'(arb_winner)*PAY_W +: PAY_W];
    end

    assign direct_load = arb_fire && !busy_q && q_empty;
    assign q_push      = arb_fire && !direct_load;

    txn_pend_fifo #(.W($bits(cmd_t)), .DEPTH(QDEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .wdata (new_cmd),
        .pop   (q_pop),
        .rdata (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    txn_frame_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (link_rst),
        .in_valid (rx_valid),
        .in_byte  (rx_byte),
        .fr_valid (fr_valid),
        .fr_id    (fr_id),
        .fr_len   (fr_len),
        .fr_data  (fr_data)
    );

    assign fr_cls       = classify(fr_id);
    assign frame_ok     = fr_valid && !link_rst;
    assign match        = frame_ok && (fr_cls == CLS_SYNC) && busy_q && sent_q
                          && (fr_id == slot_q.id);
    assign abort        = link_rst && busy_q;
    assign release_slot = match || abort;
    assign q_pop        = !q_empty && (!busy_q || release_slot);

    assign cmd_valid = busy_q && !sent_q;
    assign cmd_id    = slot_q.id;
    assign cmd_len   = slot_q.len;
    assign cmd_data  = slot_q.data;

    // In-flight slot: load from the queue head first, else directly, else release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            busy_q <= 1'b0;
            sent_q <= 1'b0;
        end else if (q_pop) begin
            slot_q <= q_head;
            busy_q <= 1'b1;
            sent_q <= 1'b0;
        end else if (direct_load) begin
            slot_q <= new_cmd;
            busy_q <= 1'b1;
            sent_q <= 1'b0;
        end else if (release_slot) begin
            busy_q <= 1'b0;
            sent_q <= 1'b0;
        end else if (cmd_valid && cmd_ready) begin
            sent_q <= 1'b1;
        end
    end

    // Result and event outputs, registered one edge after the frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= '0;
            rsp_ok      <= 1'b0;
            out_len     <= '0;
            out_data    <= '0;
            key_evt     <= 1'b0;
            touch_evt   <= 1'b0;
            oob_evt     <= 1'b0;
            unknown_evt <= 1'b0;
        end else begin
            done        <= '0;
            key_evt     <= 1'b0;
            touch_evt   <= 1'b0;
            oob_evt     <= 1'b0;
            unknown_evt <= 1'b0;
            if (abort) begin
                done[slot_q.owner] <= 1'b1;
                rsp_ok   <= 1'b0;
                out_len  <= '0;
                out_data <= '0;
            end else if (frame_ok) begin
                out_len  <= fr_len;
                out_data <= fr_data;
                case (fr_cls)
                    CLS_SYNC: begin
                        if (match) begin
                            done[slot_q.owner] <= 1'b1;
                            rsp_ok <= 1'b1;
                        end else begin
                            oob_evt <= 1'b1;
                        end
                    end
                    CLS_KEY:   key_evt     <= 1'b1;
                    CLS_TOUCH: touch_evt   <= 1'b1;
                    default:   unknown_evt <= 1'b1;
                endcase
            end
        end
    end

    p_done_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));
    p_done_needs_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |-> $past(busy_q));
    p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !link_rst) |=> (cmd_valid && $stable(cmd_id)));
    p_single_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_valid & req_ready));
    p_async_keeps_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && fr_cls != CLS_SYNC && busy_q && !link_rst) |=> busy_q);
    p_abort_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_rst && busy_q) |=> ((|done) && !rsp_ok));
endmodule

// File: tb/test_txn_mgr.sv
module test_txn_mgr;
    localparam int CLK_PERIOD = 10;
    localparam int NREQ = 2;
    localparam int PB   = 2;
    // Expected class per identifier 0..15: 0 sync (oob when idle), 1 key, 2 touch, 3 unknown.
    localparam logic [1:0] EXP_CLS [16] = '{2'd0, 2'd0, 2'd0, 2'd3, 2'd1, 2'd2, 2'd0, 2'd3,
                                            2'd0, 2'd0, 2'd3, 2'd3, 2'd3, 2'd0, 2'd3, 2'd3};

    logic clk = 1'b0, rst_n = 1'b0, link_rst = 1'b0;
    logic [NREQ-1:0] req_valid = '0, req_ready;
    logic [NREQ*4-1:0] req_id = '0, req_len = '0;
    logic [NREQ*PB*8-1:0] req_data = '0;
    logic cmd_valid, cmd_ready = 1'b1;
    logic [3:0] cmd_id, cmd_len;
    logic [PB*8-1:0] cmd_data;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [NREQ-1:0] done;
    logic rsp_ok, key_evt, touch_evt, oob_evt, unknown_evt;
    logic [3:0] out_len;
    logic [119:0] out_data;

    int n_checks = 0, n_fail = 0;
    int done_cnt = 0, key_cnt = 0, touch_cnt = 0, oob_cnt = 0, unk_cnt = 0;
    logic [NREQ-1:0] last_done = '0;
    logic last_ok = 1'b0;
    logic [3:0] last_len = '0, evt_len = '0;
    logic [119:0] last_data = '0, evt_data = '0;
    logic [3:0] cmd_log [32];
    int cmd_n = 0;

    txn_mgr #(.NREQ(NREQ), .PAY_BYTES(PB), .QDEPTH(4)) i_txn_mgr (
        .clk(clk), .rst_n(rst_n), .link_rst(link_rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
        .req_len(req_len), .req_data(req_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_id(cmd_id),
        .cmd_len(cmd_len), .cmd_data(cmd_data),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .done(done), .rsp_ok(rsp_ok), .out_len(out_len), .out_data(out_data),
        .key_evt(key_evt), .touch_evt(touch_evt), .oob_evt(oob_evt),
        .unknown_evt(unknown_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Output monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done != '0) begin
                done_cnt++; last_done = done; last_ok = rsp_ok;
                last_len = out_len; last_data = out_data;
            end
            if (key_evt)     begin key_cnt++;   evt_len = out_len; evt_data = out_data; end
            if (touch_evt)   begin touch_cnt++; evt_len = out_len; evt_data = out_data; end
            if (oob_evt)     oob_cnt++;
            if (unknown_evt) unk_cnt++;
            if (cmd_valid && cmd_ready && cmd_n < 32) begin
                cmd_log[cmd_n] = cmd_id; cmd_n++;
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic check_eq(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b; tick(); rx_valid = 1'b0;
    endtask

    task automatic send_frame(input logic [3:0] id, input logic [3:0] len,
                              input logic [119:0] d, input bit corrupt);
        logic [7:0] s;
        s = {id, len};
        send_byte(8'h02);
        send_byte({id, len});
        for (int k = 0; k < int'(len); k++) begin
            send_byte(d[k*8 +: 8]); s = s + d[k*8 +: 8];
        end
        send_byte(corrupt ? (s ^ 8'h5A) : s);
    endtask

    task automatic do_req(input int r, input logic [3:0] id, input logic [3:0] len,
                          input logic [15:0] data);
        req_valid[r] = 1'b1;
        req_id[r*4 +: 4] = id; req_len[r*4 +: 4] = len; req_data[r*16 +: 16] = data;
        for (int k = 0; k < 50 && !req_ready[r]; k++) tick();
        tick();
        req_valid[r] = 1'b0;
    endtask

    initial begin
        int d0, o0, k0, c0;
        logic [3:0] exp_ids [5];
        exp_ids = '{4'd0, 4'd1, 4'd2, 4'd8, 4'd9};
        wait_n(3);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check_eq("R1 cmd_valid", cmd_valid, 0);
        check_eq("R1 done", done, 0);
        check_eq("R1 req_ready", req_ready, 2'b11);
        check_eq("R1 events", {key_evt, touch_evt, oob_evt, unknown_evt}, 0);

        // Table walk: every identifier with the slot idle (R7, R8, R9)
        for (int id = 0; id < 16; id++) begin
            int ko, to, oo, uo, obs;
            ko = key_cnt; to = touch_cnt; oo = oob_cnt; uo = unk_cnt;
            send_frame(4'(id), 4'd1, {112'd0, 8'h30 + 8'(id)}, 1'b0);
            wait_n(3);
            obs = ((oob_cnt - oo) + (key_cnt - ko) + (touch_cnt - to) + (unk_cnt - uo) != 1) ? 7 :
                  (oob_cnt != oo) ? 0 : (key_cnt != ko) ? 1 : (touch_cnt != to) ? 2 : 3;
            case (EXP_CLS[id])
                2'd0: check_eq("R7 idle sync reply out-of-band", obs, 0);
                2'd1: check_eq("R8 key event", obs, 1);
                2'd2: check_eq("R8 touch event", obs, 2);
                default: check_eq("R9 unknown id", obs, 3);
            endcase
            if (EXP_CLS[id] == 2'd1 || EXP_CLS[id] == 2'd2)
                check_eq("R8 event data", {evt_len, evt_data[7:0]}, {4'd1, 8'h30 + 8'(id)});
        end
        check_eq("R4 no done while idle", done_cnt, 0);

        // Basic transaction (R3, R4)
        do_req(0, 4'd1, 4'd2, 16'hBEEF);
        check_eq("R3 cmd fields", {cmd_id, cmd_len, cmd_data}, {4'd1, 4'd2, 16'hBEEF});
        tick();
        send_frame(4'd1, 4'd2, {104'd0, 16'hBBAA}, 1'b0);
        wait_n(3);
        check_eq("R4 done count", done_cnt, 1);
        check_eq("R4 done owner", last_done, 2'b01);
        check_eq("R4 reply", {last_ok, last_len, last_data[15:0]}, {1'b1, 4'd2, 16'hBBAA});

        // Mismatched reply is out-of-band, then the right one completes (R7, R4)
        do_req(1, 4'd9, 4'd0, 16'h0);
        tick();
        o0 = oob_cnt;
        send_frame(4'd6, 4'd1, {112'd0, 8'h11}, 1'b0);
        wait_n(3);
        check_eq("R7 mismatch oob", oob_cnt - o0, 1);
        check_eq("R7 mismatch no done", done_cnt, 1);
        send_frame(4'd9, 4'd0, 120'd0, 1'b0);
        wait_n(3);
        check_eq("R4 owner 1 done", {last_done, last_len}, {2'b10, 4'd0});

        // Asynchronous event while a command is outstanding (R8)
        do_req(0, 4'd13, 4'd1, 16'h0040);
        tick();
        k0 = key_cnt;
        send_frame(4'd4, 4'd2, {104'd0, 16'h5566}, 1'b0);
        wait_n(3);
        check_eq("R8 key during in-flight", key_cnt - k0, 1);
        check_eq("R8 no completion", done_cnt, 2);
        send_frame(4'd13, 4'd1, {112'd0, 8'h77}, 1'b0);
        wait_n(3);
        check_eq("R8 in-flight kept then done", {done_cnt[3:0], last_data[7:0]}, {4'd3, 8'h77});

        // Bad checksum dropped, noise skipped (R2)
        do_req(0, 4'd1, 4'd0, 16'h0);
        tick();
        send_byte(8'h55); send_byte(8'hF0);
        send_frame(4'd1, 4'd1, {112'd0, 8'h01}, 1'b1);
        wait_n(3);
        check_eq("R2 bad checksum ignored", {done_cnt[3:0], 4'(oob_cnt)}, {4'd3, 4'(oob_cnt)});
        send_frame(4'd1, 4'd1, {112'd0, 8'h01}, 1'b0);
        wait_n(3);
        check_eq("R2 good frame after noise", done_cnt, 4);

        // Queue fill, back-pressure and order (R3, R5, R6)
        cmd_ready = 1'b0;
        for (int k = 0; k < 5; k++) do_req(0, exp_ids[k], 4'd0, 16'h0);
        check_eq("R3 first held", {cmd_valid, cmd_id}, {1'b1, 4'd0});
        req_valid[0] = 1'b1; req_id[3:0] = 4'd6; #1;
        check_eq("R6 full ready low", req_ready, 2'b00);
        tick();
        req_valid[0] = 1'b0;
        c0 = cmd_n; d0 = done_cnt;
        cmd_ready = 1'b1;
        for (int k = 0; k < 5; k++) begin
            wait_n(2);
            send_frame(exp_ids[k], 4'd0, 120'd0, 1'b0);
            wait_n(2);
        end
        wait_n(2);
        check_eq("R5 launches", cmd_n - c0, 5);
        for (int k = 0; k < 5; k++) check_eq("R5 order", cmd_log[c0 + k], exp_ids[k]);
        check_eq("R5 completions", done_cnt - d0, 5);

        // Arbitration (R11)
        req_valid = 2'b11; req_id = {4'd8, 4'd2}; req_len = '0; #1;
        check_eq("R11 lowest wins", req_ready, 2'b01);
        tick();
        req_valid = 2'b10;
        tick();
        req_valid = 2'b00;
        wait_n(2);
        send_frame(4'd2, 4'd0, 120'd0, 1'b0);
        wait_n(3);
        check_eq("R11 first owner", last_done, 2'b01);
        wait_n(2);
        send_frame(4'd8, 4'd0, 120'd0, 1'b0);
        wait_n(3);
        check_eq("R11 second owner", last_done, 2'b10);

        // Link reset abort mid-frame (R10)
        do_req(0, 4'd0, 4'd0, 16'h0);
        tick();
        d0 = done_cnt; o0 = oob_cnt;
        send_byte(8'h02); send_byte(8'h02); send_byte(8'h11);
        link_rst = 1'b1; tick(); link_rst = 1'b0;
        wait_n(2);
        check_eq("R10 abort done", done_cnt - d0, 1);
        check_eq("R10 abort result", {last_done, last_ok, last_len}, {2'b01, 1'b0, 4'd0});
        send_byte(8'h22); send_byte(8'h35);
        wait_n(3);
        check_eq("R10 tail ignored", {4'(done_cnt - d0), 4'(oob_cnt - o0), cmd_valid}, {4'd1, 4'd0, 1'b0});

        summary();
        $finish;
    end
endmodule